// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the bus-facing front end of a 256-byte serial memory. It samples the two-wire clock and data lines with the system clock. It recognises start and stop conditions and shifts bytes in on rising bus-clock edges. It answers only when the address byte carries the fixed code `1010` followed by the three strap inputs.

A write transfer first loads the internal address counter from the word-address byte. Every later byte is acknowledged and handed to the page write engine as an address/data strobe, and the engine is told to commit when the master sends stop. A read transfer takes bytes from the storage read port at the counter, moves each one out after a falling bus-clock edge, and keeps going while the master acknowledges. These transfers combine into byte write, page write, current-address read, random read and sequential read.

While the write engine reports busy, the block refuses its address, so a master can poll for completion. The block never drives the data line high. It only pulls it low through an output enable.

Top module: `twsMemSlave`

## Requirements
- R1: A start condition (data falls while the clock is high) moves the block to the address phase from any state. A stop condition (data rises while the clock is high) returns it to idle with the data line released.
- R2: The address byte, sent most significant bit first, is acknowledged (data held low during the ninth clock) only if bits 7..4 are `1010` and bits 3..1 equal `strapAddr`. On a mismatch there is no acknowledge, and every later byte is ignored until the next start.
- R3: While `wrBusy` is high, a matching address byte is not acknowledged.
- R4: In a write (address bit 0 = 0), the second byte loads the address counter. Each further byte is acknowledged and presented for one cycle on `wrValid`, with `wrAddr` set to the counter and `wrData` set to the byte.
- R5: After each write byte, only the low three bits of the counter advance, so the address wraps within its 8-byte page.
- R6: `wrCommit` pulses for one cycle at a stop that follows at least one write data byte. It does not pulse after a write that carried only the word address.
- R7: A read (address bit 0 = 1) sends the byte at the counter and then advances the counter by one. The counter keeps its value between transfers.
- R8: A word-address-only write, followed by a repeated start and a read address, returns data from that word address.
- R9: A read sends one byte after another for as long as the master acknowledges, with the counter wrapping from 0xFF to 0x00. A missing master acknowledge, followed by stop, ends the read.
- R10: `sdaOe` (1 = pull the line low) changes only while the sampled clock is low.
- R11: A start in the middle of a byte abandons that byte and leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaOe | output | 1 | Pull data line low when 1 |
| strapAddr | input | 3 | Device select straps |
| wrBusy | input | 1 | Write engine internal cycle in progress |
| wrValid | output | 1 | One-cycle write byte strobe |
| wrAddr | output | 8 | Address of the write byte |
| wrData | output | 8 | Write byte |
| wrCommit | output | 1 | Start internal write cycle (after stop) |
| rdAddr | output | 8 | Storage read address (current counter) |
| rdData | input | 8 | Storage read data for `rdAddr` |

## Verification
The bound assertions check, on every cycle, that the data-line enable only moves while the clock is low and is released in idle. They also check that write strobes and commit pulses are single-cycle and never coincide, that the bit count stays in range, and that no address acknowledge begins while the write engine is busy. Only the bench scenarios can show the transfer-level behaviour: page wrap on writes, wrap from 0xFF on reads, counter retention across transfers, random reads through a repeated start, abandonment of a byte by a mid-byte start, and the missing commit after an address-only write. The bench checks these against a reference memory model.

// File: rtl/twsPkg.sv
package twsPkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_WADDR,
    PH_WDATA,
    PH_READ
  } phase_t;

  typedef struct packed {
    logic shiftRx;
    logic setAddr;
    logic incWr;
    logic loadTx;
    logic shiftTx;
  } dpCtl_t;
endpackage

// File: rtl/twsBusSampler.sv
module twsBusSampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [STAGES-1:0] sclSh, sdaSh;
  logic sclPrev, sdaPrev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSh[g] <= 1'b1;
          sdaSh[g] <= 1'b1;
        end else if (g == 0) begin
          sclSh[g] <= sclIn;
          sdaSh[g] <= sdaIn;
        end else begin
          sclSh[g] <= sclSh[g-1];
          sdaSh[g] <= sdaSh[g-1];
        end
      end
    end
  endgenerate

  assign sclS = sclSh[STAGES-1];
  assign sdaS = sdaSh[STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
endmodule

// File: rtl/twsCtrl.sv
module twsCtrl
  import twsPkg::*;
#(
  parameter int         STRAP_W  = 3,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclRise,
  input  logic               sclFall,
  input  logic               startDet,
  input  logic               stopDet,
  input  logic               sdaS,
  input  logic [7:0]         rxByte,
  input  logic [STRAP_W-1:0] strap,
  input  logic               wrBusy,
  output dpCtl_t             dp,
  output logic               wrCommit,
  output logic               ackDrive,
  output logic               txEn,
  output phase_t             phase,
  output logic [3:0]         bitCnt
);
  localparam int ID_W = 4 + STRAP_W;

  logic rwBit, mAck, wrPend, ackOk;
  logic ackSlot, endSlot;

  assign ackSlot = sclFall && (bitCnt == 4'd8);
  assign endSlot = sclFall && (bitCnt == 4'd9);

  always_comb begin
    unique case (phase)
      PH_DEV:            ackOk = (rxByte[7:8-ID_W] == {DEV_CODE, strap}) && !wrBusy;
      PH_WADDR, PH_WDATA: ackOk = 1'b1;
      default:           ackOk = 1'b0;
    endcase
  end

  always_comb begin
    dp = '0;
    if (!startDet && !stopDet) begin
      dp.shiftRx = sclRise && (bitCnt < 4'd8) &&
                   (phase == PH_DEV || phase == PH_WADDR || phase == PH_WDATA);
      dp.setAddr = ackSlot && (phase == PH_WADDR);
      dp.incWr   = ackSlot && (phase == PH_WDATA);
      dp.loadTx  = endSlot && ((phase == PH_DEV && ackDrive && rwBit) ||
                               (phase == PH_READ && mAck));
      dp.shiftTx = sclFall && (phase == PH_READ) && (bitCnt >= 4'd1) && (bitCnt <= 4'd7);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txEn     <= 1'b0;
      rwBit    <= 1'b0;
      mAck     <= 1'b0;
      wrPend   <= 1'b0;
      wrCommit <= 1'b0;
    end else begin
      wrCommit <= 1'b0;
      if (startDet) begin
        phase    <= PH_DEV;
        bitCnt   <= '0;
        ackDrive <= 1'b0;
        txEn     <= 1'b0;
        wrPend   <= 1'b0;
      end else if (stopDet) begin
        phase    <= PH_IDLE;
        ackDrive <= 1'b0;
        txEn     <= 1'b0;
        wrCommit <= wrPend;
        wrPend   <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (sclRise) begin
          if (bitCnt < 4'd9) bitCnt <= bitCnt + 4'd1;
          if (phase == PH_READ && bitCnt == 4'd8) mAck <= ~sdaS;
        end
        if (ackSlot) begin
          if (phase == PH_READ) txEn <= 1'b0;
          else ackDrive <= ackOk;
          if (phase == PH_DEV) rwBit <= rxByte[0];
          if (phase == PH_WDATA) wrPend <= 1'b1;
        end
        if (endSlot) begin
          bitCnt   <= '0;
          ackDrive <= 1'b0;
          unique case (phase)
            PH_DEV: begin
              if (!ackDrive) phase <= PH_IDLE;
              else if (rwBit) begin
                phase <= PH_READ;
                txEn  <= 1'b1;
              end else phase <= PH_WADDR;
            end
            PH_WADDR: phase <= PH_WDATA;
            PH_READ: begin
              if (mAck) txEn <= 1'b1;
              else phase <= PH_IDLE;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/twsData.sv
module twsData
  import twsPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dp,
  input  logic              sdaS,
  input  logic [7:0]        rdData,
  output logic [7:0]        rxByte,
  output logic              txMsb,
  output logic [ADDR_W-1:0] addrCnt
);
  logic [7:0] txByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      txByte  <= '0;
      addrCnt <= '0;
    end else begin
      if (dp.shiftRx) rxByte <= {rxByte[6:0], sdaS};
      if (dp.setAddr) addrCnt <= rxByte[ADDR_W-1:0];
      else if (dp.incWr)
        addrCnt[PAGE_W-1:0] <= addrCnt[PAGE_W-1:0] + 1'b1;
      else if (dp.loadTx) addrCnt <= addrCnt + 1'b1;
      if (dp.loadTx) txByte <= rdData;
      else if (dp.shiftTx) txByte <= {txByte[6:0], 1'b0};
    end
  end

  assign txMsb = txByte[7];
endmodule

// File: rtl/twsMemSlave.sv
module twsMemSlave
  import twsPkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 3,
  parameter int STRAP_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaOe,
  input  logic [STRAP_W-1:0] strapAddr,
  input  logic               wrBusy,
  output logic               wrValid,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [7:0]         wrData,
  output logic               wrCommit,
  output logic [ADDR_W-1:0]  rdAddr,
  input  logic [7:0]         rdData
);
  logic sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  logic ackDrive, txEn, txMsb;
  logic [7:0] rxByte;
  logic [3:0] bitCnt;
  logic [ADDR_W-1:0] addrCnt;
  phase_t phase;
  dpCtl_t dp;

  twsBusSampler #(.STAGES(SYNC_STAGES)) uSample (
    .clk, .rstN, .sclIn, .sdaIn, .sclS, .sdaS,
    .sclRise, .sclFall, .startDet, .stopDet
  );

  twsCtrl #(.STRAP_W(STRAP_W)) uCtrl (
    .clk, .rstN, .sclRise, .sclFall, .startDet, .stopDet, .sdaS,
    .rxByte, .strap(strapAddr), .wrBusy, .dp, .wrCommit,
    .ackDrive, .txEn, .phase, .bitCnt
  );

  twsData #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) uData (
    .clk, .rstN, .dp, .sdaS, .rdData, .rxByte, .txMsb, .addrCnt
  );

  assign sdaOe   = ackDrive | (txEn & ~txMsb);
  assign wrValid = dp.incWr;
  assign wrAddr  = addrCnt;
  assign wrData  = rxByte;
  assign rdAddr  = addrCnt;
endmodule

// File: rtl/twsMemSlaveChk.sv
module twsMemSlaveChk
  import twsPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       sclS,
  input logic       sdaOe,
  input logic       ackDrive,
  input logic       wrBusy,
  input logic       wrValid,
  input logic       wrCommit,
  input phase_t     phase,
  input logic [3:0] bitCnt
);
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !sclS);

  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE) |-> !sdaOe);

  p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !wrValid);

  p_commit_alone_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrValid, wrCommit}));

  p_bit_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= 4'd9);

  p_busy_nack_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ackDrive) && $past(phase) == PH_DEV) |-> !$past(wrBusy));
endmodule

bind twsMemSlave twsMemSlaveChk uChk (
  .clk, .rstN, .sclS, .sdaOe, .ackDrive, .wrBusy,
  .wrValid, .wrCommit, .phase, .bitCnt
);

// File: tb/test_twsMemSlave.sv
module test_twsMemSlave;
  localparam int Q = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0, rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic sdaOe, wrValid, wrCommit;
  logic [7:0] wrAddr, wrData, rdAddr, rdData;
  logic sdaLine;
  logic [7:0] mem [256];
  logic [7:0] expMem [256];
  logic [7:0] expCnt;
  int busyCnt = 0, wrCount = 0, commitCount = 0, oeViol = 0;
  int checks = 0, fails = 0;
  logic wrBusy;
  logic prevOe = 1'b0;

  always #4 clk = ~clk;

  assign sdaLine = sdaDrv & ~sdaOe;
  assign wrBusy  = (busyCnt != 0);
  assign rdData  = mem[rdAddr];

  twsMemSlave i_twsMemSlave (
    .clk, .rstN, .sclIn(sclDrv), .sdaIn(sdaLine), .sdaOe,
    .strapAddr(STRAP), .wrBusy, .wrValid, .wrAddr, .wrData,
    .wrCommit, .rdAddr, .rdData
  );

  initial for (int i = 0; i < 256; i++) begin
    mem[i] = 8'(i) ^ 8'hA5;
    expMem[i] = 8'(i) ^ 8'hA5;
  end

  always @(posedge clk) begin
    if (wrValid) begin
      mem[wrAddr] <= wrData;
      wrCount <= wrCount + 1;
    end
    if (wrCommit) begin
      busyCnt <= 400;
      commitCount <= commitCount + 1;
    end else if (busyCnt != 0) busyCnt <= busyCnt - 1;
    if (rstN && sdaOe != prevOe && sclDrv) oeViol <= oeViol + 1;
    prevOe <= sdaOe;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ(int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitQ(); sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b0; waitQ(); sclDrv = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitQ(); sclDrv = 1'b1; waitQ(); sdaDrv = 1'b1; waitQ();
  endtask

  task automatic putBit(logic b);
    sdaDrv = b; waitQ(); sclDrv = 1'b1; waitQ(2); sclDrv = 1'b0; waitQ();
  endtask

  task automatic getBit(output logic b);
    sdaDrv = 1'b1; waitQ(); sclDrv = 1'b1; waitQ(); b = sdaLine;
    waitQ(); sclDrv = 1'b0; waitQ();
  endtask

  task automatic sendByte(logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    getBit(b);
    acked = ~b;
  endtask

  task automatic recvByte(logic masterAck, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      v[i] = b;
    end
    putBit(~masterAck);
  endtask

  function automatic logic [7:0] pageNext(logic [7:0] a);
    return {a[7:3], a[2:0] + 3'd1};
  endfunction

  task automatic pollReady(string req);
    logic ack;
    int tries = 0;
    do begin
      busStart();
      sendByte(DEV_W, ack);
      busStop();
      if (tries == 0) chk({req, " first poll refused while busy"}, ack, 1'b0);
      tries++;
    end while (!ack && tries < 20);
    chk({req, " poll eventually acked"}, ack, 1'b1);
  endtask

  task automatic pageWrite(string req, logic [7:0] a, int n, logic [7:0] seed);
    logic ack;
    int w0 = wrCount, c0 = commitCount;
    busStart();
    sendByte(DEV_W, ack); chk({req, " dev ack"}, ack, 1'b1);
    sendByte(a, ack);     chk({req, " waddr ack"}, ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d = seed + 8'(i * 37);
      sendByte(d, ack);
      chk({req, " data ack"}, ack, 1'b1);
      expMem[a] = d;
      a = pageNext(a);
    end
    busStop();
    expCnt = a;
    waitQ();
    chk({req, " R4 strobe count"}, wrCount - w0, n);
    chk({req, " R6 commit count"}, commitCount - c0, 1);
    pollReady("R3");
  endtask

  task automatic readBytes(string req, int n);
    logic [7:0] v;
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, v);
      chk(req, v, expMem[expCnt]);
      expCnt = expCnt + 8'd1;
    end
    busStop();
  endtask

  task automatic currentRead(string req, int n);
    logic ack;
    busStart();
    sendByte(DEV_R, ack); chk({req, " read ack"}, ack, 1'b1);
    readBytes(req, n);
  endtask

  task automatic randomRead(string req, logic [7:0] a, int n);
    logic ack;
    busStart();
    sendByte(DEV_W, ack); chk({req, " dev ack"}, ack, 1'b1);
    sendByte(a, ack);     chk({req, " waddr ack"}, ack, 1'b1);
    expCnt = a;
    busStart();
    sendByte(DEV_R, ack); chk({req, " read ack"}, ack, 1'b1);
    readBytes(req, n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] v;
    int w0, c0;
    void'($urandom(32'h5EED_0042));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    waitQ();
    chk("R1 reset sdaOe", sdaOe, 1'b0);
    chk("R1 reset wrValid", wrValid, 1'b0);
    expCnt = 8'h00;

    // R2: wrong straps are refused and later bytes ignored
    w0 = wrCount;
    busStart();
    sendByte({4'b1010, ~STRAP, 1'b0}, ack); chk("R2 mismatch no ack", ack, 1'b0);
    sendByte(8'h10, ack);                   chk("R2 ignored byte no ack", ack, 1'b0);
    busStop();
    chk("R2 no strobe after mismatch", wrCount - w0, 0);
    // R2: wrong fixed code
    busStart();
    sendByte({4'b1011, STRAP, 1'b0}, ack); chk("R2 wrong code no ack", ack, 1'b0);
    busStop();

    // R4 byte write, R5 page wrap
    pageWrite("R4 byte", 8'h20, 1, 8'h5A);
    pageWrite("R5 wrap", 8'h3D, 5, 8'h11);
    chk("R5 counter after wrap", 32'(expCnt), 32'h3A);

    // R7 current-address read (counter kept between transfers)
    currentRead("R7 current read", 1);
    currentRead("R7 next current read", 1);

    // R8 random read of the wrapped bytes
    randomRead("R8 random read", 8'h38, 2);
    randomRead("R5 wrapped bytes", 8'h3D, 3);

    // R9 sequential read across 0xFF
    randomRead("R9 sequential wrap", 8'hFE, 4);
    currentRead("R9 after nack stop", 1);

    // R6 address-only write then stop: no commit, counter loaded
    c0 = commitCount;
    busStart();
    sendByte(DEV_W, ack); sendByte(8'h77, ack);
    busStop();
    waitQ();
    chk("R6 no commit without data", commitCount - c0, 0);
    expCnt = 8'h77;
    currentRead("R4 counter from word address", 1);

    // R11 start mid-byte abandons it
    busStart();
    sendByte(DEV_W, ack);
    for (int i = 0; i < 4; i++) putBit(1'b0);
    busStart();
    sendByte(DEV_R, ack); chk("R11 ack after restart", ack, 1'b1);
    readBytes("R11 counter unchanged", 1);

    // random traffic
    for (int t = 0; t < 5; t++) begin
      logic [7:0] a = 8'($urandom);
      int n = 1 + int'($urandom % 10);
      pageWrite("R5 random page write", a, n, 8'($urandom));
      randomRead("R9 random sequential read", {a[7:3], 3'd0}, 8);
      currentRead("R7 random current read", 1 + int'($urandom % 3));
    end

    chk("R10 sdaOe changed only while clock low", oeViol, 0);
    chk("R1 released after stop", sdaOe, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule